// File: doc/BRIEF.md
# Write/Read Request Packetizer with Linear Header Merging

This block turns memory-bus packet requests into a stream of flits for a narrow on-chip network link. Every flit is one data word plus one mask bit per data byte, so the default 64-bit data path yields a 72-bit flit. A packet is a header flit followed by its payload flits. The header carries the route, the QoS level, a size code, the access type, the start address and a continuation flag. A write packet then sends one payload flit per data word. A read packet sends only its header, and the size code tells the target how much data to return.

Requests arrive one packet at a time on a command port, and each carries a flag that closes its transaction. Write data comes in on a separate beat port with byte enables. Within a transaction, a write packet that follows a write with the same route, QoS and size, and that starts at the byte just past that write, carries no header of its own. A linear burst split into packets therefore pays for only one header flit. When the chain breaks, the packet gets a fresh header with its continuation flag set. The flit output uses valid/ready and has three sideband bits: header, last of packet and last of transaction. An arbiter downstream can use the last-of-transaction bit to release its grant.

Top module: `flit_packer`

## Requirements
- R1: A payload flit holds the write data in bits [DATA_W-1:0] and the byte mask in the bits above it. The header sideband bit is low on payload flits.
- R2: A header flit has route in [3:0], QoS in [7:4], size code in [9:8], write=1/read=0 in [10], start address in [42:11] and continuation flag in [43]. All higher bits are zero and the header sideband bit is high.
- R3: The size codes 0, 1, 2 and 3 mean 4, 8, 16 and 32 bytes. A write packet sends max(1, bytes/(DATA_W/8)) payload flits. A lone 32-byte write on the 64-bit path therefore costs exactly 5 flits.
- R4: In a packet smaller than the data word, mask bits are cleared outside the naturally aligned window of the packet size that holds the start address. Inside that window the mask equals the byte enables.
- R5: A read packet emits only its header, with last-of-packet set, and takes no write-data beats.
- R6: A write packet is sent without a header when it is not the first of its transaction and all of the following hold for the previous packet of that transaction: it was also a write, with equal route, QoS and size code, and the new start address equals its start address plus its size.
- R7: Every other packet gets a header. That header's continuation flag is 1 exactly when the packet is not the first of its transaction.
- R8: Last-of-packet marks the final flit of each packet. Last-of-transaction marks that same flit only for the packet whose command had its last flag set, and it never appears without last-of-packet.
- R9: While flit_valid is high and flit_ready is low, the flit and its sideband bits stay unchanged on the next cycle.
- R10: The first packet of a new transaction is accepted only when no flit is waiting at the output, so all flits of the previous transaction have been sent.
- R11: After reset, flit_valid is low and cmd_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Packet request valid |
| cmd_ready | output | 1 | Packet request accepted this cycle |
| cmd_dest | input | 4 | Route ID |
| cmd_qos | input | 4 | QoS level |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 32 | Packet start address |
| cmd_size | input | 2 | Size code (4 << code bytes) |
| cmd_last | input | 1 | Packet closes its transaction |
| wdata_valid | input | 1 | Write beat valid |
| wdata_ready | output | 1 | Write beat taken |
| wdata | input | DATA_W | Write beat data |
| wstrb | input | DATA_W/8 | Write beat byte enables |
| flit_valid | output | 1 | Flit valid |
| flit_ready | input | 1 | Link accepts flit |
| flit_data | output | DATA_W+DATA_W/8 | Flit contents |
| flit_hdr | output | 1 | Flit is a header |
| flit_lop | output | 1 | Last flit of packet |
| flit_lot | output | 1 | Last flit of transaction |

## Verification
The bench builds the block with its default 64-bit data path, which gives 72-bit flits. With that width, 4-byte packets exercise partial-lane masking in both halves of the word, and 16- and 32-byte packets need two and four payload beats. Random chains that are mostly linear and are broken now and then by an address jump, a size change, a read or a new transaction exercise both the merge decision and the header-per-packet path. Because flit_ready and the write-beat valid are throttled at random, backpressure holds headers and payload in place, and new transactions arrive while older flits are still draining.

// File: rtl/fpk_pkg.sv
package fpk_pkg;
  // header field widths; positions follow from the packing order in hdr_pack
  localparam int DEST_W  = 4;
  localparam int QOS_W   = 4;
  localparam int SZ_W    = 2;
  localparam int HADDR_W = 32;
  localparam int HDR_W   = DEST_W + QOS_W + SZ_W + 1 + HADDR_W + 1;
  localparam int HDR_WR_BIT = DEST_W + QOS_W + SZ_W;

  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_BODY} seq_state_e;

  typedef struct packed {
    logic [DEST_W-1:0]  dest;
    logic [QOS_W-1:0]   qos;
    logic [SZ_W-1:0]    szc;
    logic               wr;
    logic [HADDR_W-1:0] addr;
    logic               last;
  } pkt_cmd_t;

  // size code to byte count: 4, 8, 16, 32
  function automatic int unsigned size_bytes(input logic [SZ_W-1:0] c);
    return 32'd4 << c;
  endfunction

  // address a linearly continuing packet must start at
  function automatic logic [HADDR_W-1:0] next_linear(input logic [HADDR_W-1:0] a,
                                                     input logic [SZ_W-1:0] c);
    return a + HADDR_W'(size_bytes(c));
  endfunction

  // header layout, LSB first: dest, qos, size, type, address, continuation
  function automatic logic [HDR_W-1:0] hdr_pack(input pkt_cmd_t c, input logic cont);
    return {cont, c.addr, c.wr, c.szc, c.qos, c.dest};
  endfunction
endpackage

// File: rtl/fpk_linear_track.sv
module fpk_linear_track
  import fpk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cmd_fire,
  input  pkt_cmd_t cmd,
  output logic     hdr_skip,
  output logic     txn_open
);
  logic               open_q;
  logic               prev_wr_q;
  logic [DEST_W-1:0]  prev_dest_q;
  logic [QOS_W-1:0]   prev_qos_q;
  logic [SZ_W-1:0]    prev_szc_q;
  logic [HADDR_W-1:0] want_addr_q;

  logic same_route;
  logic addr_hit;

  assign same_route = (cmd.dest == prev_dest_q) && (cmd.qos == prev_qos_q) &&
                      (cmd.szc == prev_szc_q);
  assign addr_hit   = (cmd.addr == want_addr_q);
  assign hdr_skip   = open_q && cmd.wr && prev_wr_q && same_route && addr_hit;
  assign txn_open   = open_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q      <= 1'b0;
      prev_wr_q   <= 1'b0;
      prev_dest_q <= '0;
      prev_qos_q  <= '0;
      prev_szc_q  <= '0;
      want_addr_q <= '0;
    end else if (cmd_fire) begin
      open_q      <= !cmd.last;
      prev_wr_q   <= cmd.wr;
      prev_dest_q <= cmd.dest;
      prev_qos_q  <= cmd.qos;
      prev_szc_q  <= cmd.szc;
      want_addr_q <= next_linear(cmd.addr, cmd.szc);
    end
  end
endmodule

// File: rtl/fpk_seq.sv
module fpk_seq
  import fpk_pkg::*;
#(
  parameter  int DATA_W = 64,
  localparam int STRB_W = DATA_W / 8,
  localparam int FLIT_W = DATA_W + STRB_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_fire,
  input  pkt_cmd_t          cmd,
  input  logic              hdr_skip,
  input  logic              txn_open,
  input  logic              wdata_valid,
  input  logic [DATA_W-1:0] wdata,
  input  logic [STRB_W-1:0] wstrb,
  output logic              wdata_ready,
  input  logic              can_load,
  output logic              gen_valid,
  output logic [FLIT_W-1:0] gen_flit,
  output logic              gen_hdr,
  output logic              gen_lop,
  output logic              gen_lot,
  output logic              seq_idle
);
  localparam int MAX_BEATS = (32 / STRB_W > 1) ? 32 / STRB_W : 1;
  localparam int CNT_W     = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1;
  localparam int OFF_W     = $clog2(STRB_W);

  // index of the final payload beat for a size code
  function automatic logic [CNT_W-1:0] last_beat(input logic [SZ_W-1:0] c);
    int unsigned b;
    b = size_bytes(c) / STRB_W;
    return (b <= 1) ? '0 : CNT_W'(b - 1);
  endfunction

  // byte lanes covered by a packet narrower than the data word
  function automatic logic [STRB_W-1:0] lane_window(input logic [SZ_W-1:0] c,
                                                    input logic [OFF_W-1:0] off);
    int unsigned b;
    logic [STRB_W-1:0] m;
    b = size_bytes(c);
    if (b >= STRB_W) return '1;
    m = STRB_W'((1 << b) - 1);
    return m << (off & OFF_W'(~(b - 1)));
  endfunction

  seq_state_e       state_q;
  pkt_cmd_t         cur_q;
  logic             cont_q;
  logic [CNT_W-1:0] beat_q;

  logic             beat_end;
  logic             load;
  logic [STRB_W-1:0] body_mask;

  assign beat_end  = (beat_q == last_beat(cur_q.szc));
  assign body_mask = wstrb & lane_window(cur_q.szc, cur_q.addr[OFF_W-1:0]);
  assign seq_idle  = (state_q == ST_IDLE);

  always_comb begin
    gen_valid = 1'b0;
    gen_hdr   = 1'b0;
    gen_lop   = 1'b0;
    gen_flit  = '0;
    case (state_q)
      ST_HDR: begin
        gen_valid = 1'b1;
        gen_hdr   = 1'b1;
        gen_lop   = !cur_q.wr;
        gen_flit  = FLIT_W'(hdr_pack(cur_q, cont_q));
      end
      ST_BODY: begin
        gen_valid = wdata_valid;
        gen_lop   = beat_end;
        gen_flit  = {body_mask, wdata};
      end
      default: ;
    endcase
    gen_lot = gen_lop && cur_q.last;
  end

  assign load        = gen_valid && can_load;
  assign wdata_ready = (state_q == ST_BODY) && can_load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      cont_q  <= 1'b0;
      beat_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (cmd_fire) begin
          cur_q   <= cmd;
          cont_q  <= txn_open;
          beat_q  <= '0;
          state_q <= hdr_skip ? ST_BODY : ST_HDR;
        end
        ST_HDR: if (load) state_q <= cur_q.wr ? ST_BODY : ST_IDLE;
        ST_BODY: if (load) begin
          if (beat_end) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
          end else begin
            beat_q  <= beat_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fpk_out_reg.sv
module fpk_out_reg #(
  parameter int W = 75
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         can_load,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_ready
);
  logic         v_q;
  logic [W-1:0] d_q;

  assign can_load  = !v_q || out_ready;
  assign out_valid = v_q;
  assign out_data  = d_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      d_q <= '0;
    end else if (can_load) begin
      v_q <= in_valid;
      if (in_valid) d_q <= in_data;
    end
  end
endmodule

// File: rtl/flit_packer.sv
module flit_packer
  import fpk_pkg::*;
#(
  parameter  int DATA_W = 64,   // 64 or wider so a header fits in one flit
  localparam int STRB_W = DATA_W / 8,
  localparam int FLIT_W = DATA_W + STRB_W
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [DEST_W-1:0]  cmd_dest,
  input  logic [QOS_W-1:0]   cmd_qos,
  input  logic               cmd_write,
  input  logic [HADDR_W-1:0] cmd_addr,
  input  logic [SZ_W-1:0]    cmd_size,
  input  logic               cmd_last,
  input  logic               wdata_valid,
  output logic               wdata_ready,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [STRB_W-1:0]  wstrb,
  output logic               flit_valid,
  input  logic               flit_ready,
  output logic [FLIT_W-1:0]  flit_data,
  output logic               flit_hdr,
  output logic               flit_lop,
  output logic               flit_lot
);
  localparam int OUT_W = FLIT_W + 3;

  pkt_cmd_t          cmd;
  logic              cmd_fire;
  logic              hdr_skip;
  logic              txn_open;
  logic              seq_idle;
  logic              can_load;
  logic              gen_valid;
  logic [FLIT_W-1:0] gen_flit;
  logic              gen_hdr;
  logic              gen_lop;
  logic              gen_lot;
  logic [OUT_W-1:0]  out_bus;

  assign cmd = '{dest: cmd_dest, qos: cmd_qos, szc: cmd_size, wr: cmd_write,
                 addr: cmd_addr, last: cmd_last};

  // a fresh transaction waits for the output to drain
  assign cmd_ready = seq_idle && (txn_open || !flit_valid);
  assign cmd_fire  = cmd_valid && cmd_ready;

  fpk_linear_track u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_fire (cmd_fire),
    .cmd      (cmd),
    .hdr_skip (hdr_skip),
    .txn_open (txn_open)
  );

  fpk_seq #(.DATA_W(DATA_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_fire    (cmd_fire),
    .cmd         (cmd),
    .hdr_skip    (hdr_skip),
    .txn_open    (txn_open),
    .wdata_valid (wdata_valid),
    .wdata       (wdata),
    .wstrb       (wstrb),
    .wdata_ready (wdata_ready),
    .can_load    (can_load),
    .gen_valid   (gen_valid),
    .gen_flit    (gen_flit),
    .gen_hdr     (gen_hdr),
    .gen_lop     (gen_lop),
    .gen_lot     (gen_lot),
    .seq_idle    (seq_idle)
  );

  fpk_out_reg #(.W(OUT_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (gen_valid),
    .in_data   ({gen_lot, gen_lop, gen_hdr, gen_flit}),
    .can_load  (can_load),
    .out_valid (flit_valid),
    .out_data  (out_bus),
    .out_ready (flit_ready)
  );

  assign {flit_lot, flit_lop, flit_hdr, flit_data} = out_bus;
endmodule

// File: rtl/flit_packer_chk.sv
module flit_packer_chk
  import fpk_pkg::*;
#(
  parameter int FLIT_W = 72
)(
  input logic              clk,
  input logic              rst_n,
  input logic              flit_valid,
  input logic              flit_ready,
  input logic [FLIT_W-1:0] flit_data,
  input logic              flit_hdr,
  input logic              flit_lop,
  input logic              flit_lot,
  input logic              cmd_fire,
  input logic              cmd_write,
  input logic              hdr_skip,
  input logic              txn_open
);
  AST_FLIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    flit_valid && !flit_ready |=> flit_valid && $stable(flit_data) &&
    $stable({flit_hdr, flit_lop, flit_lot})); // R9

  AST_HDR_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    flit_valid && flit_hdr |-> flit_data[FLIT_W-1:HDR_W] == '0); // R2

  AST_READ_HDR_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    flit_valid && flit_hdr && !flit_data[HDR_WR_BIT] |-> flit_lop); // R5

  AST_LOT_NEEDS_LOP: assert property (@(posedge clk) disable iff (!rst_n)
    flit_valid && flit_lot |-> flit_lop); // R8

  AST_NEW_TXN_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire && !txn_open |-> !flit_valid); // R10

  AST_SKIP_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire && hdr_skip |-> cmd_write && txn_open); // R6

  AST_RESET_EMPTY: assert property (@(posedge clk)
    !rst_n |=> !flit_valid); // R11
endmodule

bind flit_packer flit_packer_chk #(.FLIT_W(FLIT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flit_valid (flit_valid),
  .flit_ready (flit_ready),
  .flit_data  (flit_data),
  .flit_hdr   (flit_hdr),
  .flit_lop   (flit_lop),
  .flit_lot   (flit_lot),
  .cmd_fire   (cmd_fire),
  .cmd_write  (cmd_write),
  .hdr_skip   (hdr_skip),
  .txn_open   (txn_open)
);

// File: tb/flit_packer_tb_top.sv
`timescale 1ns/1ps
module flit_packer_tb_top;
  localparam int DW = 64;
  localparam int SW = DW / 8;
  localparam int FW = DW + SW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [3:0]    cmd_dest = '0;
  logic [3:0]    cmd_qos = '0;
  logic          cmd_write = 1'b0;
  logic [31:0]   cmd_addr = '0;
  logic [1:0]    cmd_size = '0;
  logic          cmd_last = 1'b0;
  logic          wdata_valid = 1'b0;
  logic          wdata_ready;
  logic [DW-1:0] wdata = '0;
  logic [SW-1:0] wstrb = '0;
  logic          flit_valid;
  logic          flit_ready = 1'b0;
  logic [FW-1:0] flit_data;
  logic          flit_hdr;
  logic          flit_lop;
  logic          flit_lot;

  always #2.5 clk = ~clk;

  flit_packer #(.DATA_W(DW)) dut_i (.*);

  int n_checks = 0;
  int n_errs   = 0;
  int flits_seen = 0;
  int beats_seen = 0;
  int cycles = 0;
  int ready_pct = 70;

  logic [FW+2:0]      exp_q[$];
  string              tag_q[$];
  logic [SW+DW-1:0]   wd_q[$];

  // bench-side model of the merge decision
  bit          m_open = 0;
  bit          m_wr = 0;
  logic [3:0]  m_d = '0, m_q = '0;
  logic [1:0]  m_sz = '0;
  logic [31:0] m_next = '0;

  task automatic check(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] expv);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  function automatic logic [FW-1:0] exp_header(input logic [3:0] d, input logic [3:0] q,
      input logic [1:0] sz, input logic wr, input logic [31:0] a, input logic cont);
    logic [FW-1:0] h;
    h = '0;
    h[3:0] = d; h[7:4] = q; h[9:8] = sz; h[10] = wr; h[42:11] = a; h[43] = cont;
    return h;
  endfunction

  function automatic logic [SW-1:0] exp_mask(input logic [1:0] sz, input logic [31:0] a,
                                             input logic [SW-1:0] st);
    int bytes;
    logic [SW-1:0] m;
    bytes = 4 << sz;
    for (int i = 0; i < SW; i++)
      m[i] = (bytes >= SW) ? st[i] : (st[i] && (i / bytes) == (int'(a[2:0]) / bytes));
    return m;
  endfunction

  // flit link backpressure
  always @(negedge clk) flit_ready = (($urandom % 100) < ready_pct);

  // write beat source
  bit wd_fire = 0;
  initial begin
    forever begin
      @(negedge clk);
      if (wd_fire) begin
        void'(wd_q.pop_front());
        beats_seen++;
        wd_fire = 0;
      end
      if (wd_q.size() > 0 && ($urandom % 100) < 80) begin
        wdata_valid = 1'b1;
        {wstrb, wdata} = wd_q[0];
      end else begin
        wdata_valid = 1'b0;
      end
      #1;
      wd_fire = wdata_valid && wdata_ready;
    end
  end

  // flit monitor
  bit           hold_pend = 0;
  logic [FW+2:0] held = '0;
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n) begin
        if (hold_pend)
          check(flit_valid && {flit_lot, flit_lop, flit_hdr, flit_data} == held, "R9",
                128'({flit_valid, flit_lot, flit_lop, flit_hdr, flit_data}), 128'({1'b1, held}));
        hold_pend = flit_valid && !flit_ready;
        held = {flit_lot, flit_lop, flit_hdr, flit_data};
        if (flit_valid && flit_ready) begin
          flits_seen++;
          if (exp_q.size() == 0) begin
            check(1'b0, "R8 unexpected flit", 128'(held), 128'(0));
          end else begin
            logic [FW+2:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({flit_hdr, flit_data} == e[FW:0], t, 128'({flit_hdr, flit_data}), 128'(e[FW:0]));
            check({flit_lot, flit_lop} == e[FW+2:FW+1], "R8",
                  128'({flit_lot, flit_lop}), 128'(e[FW+2:FW+1]));
          end
        end
      end
    end
  end

  task automatic issue(input logic [3:0] d, input logic [3:0] q, input logic wr,
                       input logic [31:0] a, input logic [1:0] sz, input logic lst);
    bit merge, first;
    int bytes, nb;
    logic [DW-1:0] dat;
    logic [SW-1:0] st;
    bytes = 4 << sz;
    nb = (bytes < SW) ? 1 : bytes / SW;
    first = !m_open;
    merge = m_open && wr && m_wr && sz == m_sz && d == m_d && q == m_q && a == m_next;
    if (!merge) begin
      exp_q.push_back({lst && !wr, !wr, 1'b1, exp_header(d, q, sz, wr, a, !first)});
      tag_q.push_back(first ? "R2" : "R7");
    end
    if (wr) begin
      for (int i = 0; i < nb; i++) begin
        dat = {$urandom, $urandom};
        st = SW'($urandom);
        if (($urandom % 4) == 0) st = '1;
        exp_q.push_back({lst && i == nb - 1, i == nb - 1, 1'b0, exp_mask(sz, a, st), dat});
        tag_q.push_back((bytes < SW) ? "R4" : "R1");
        wd_q.push_back({st, dat});
      end
    end
    m_open = !lst; m_wr = wr; m_d = d; m_q = q; m_sz = sz; m_next = a + bytes;
    cmd_valid = 1'b1; cmd_dest = d; cmd_qos = q; cmd_write = wr;
    cmd_addr = a; cmd_size = sz; cmd_last = lst;
    forever begin
      #1;
      if (cmd_ready) break;
      @(negedge clk);
    end
    if (first) check(!flit_valid, "R10", 128'(flit_valid), 128'(0));
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic drain();
    int guard;
    guard = 0;
    while ((exp_q.size() != 0 || wd_q.size() != 0 || flit_valid) && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
    end
  end

  initial begin
    int f0, b0;
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    #1;
    check(!flit_valid, "R11 flit_valid", 128'(flit_valid), 128'(0));
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(!flit_valid && cmd_ready, "R11 idle", 128'({flit_valid, cmd_ready}), 128'(2'b01));
    @(negedge clk);

    // lone 32-byte write: header + 4 beats
    f0 = flits_seen;
    issue(4'h3, 4'h5, 1'b1, 32'h0000_1000, 2'd3, 1'b1);
    drain();
    check(flits_seen - f0 == 5, "R3", 128'(flits_seen - f0), 128'(5));

    // read packet: header only, no beats taken
    f0 = flits_seen; b0 = beats_seen;
    issue(4'h1, 4'h2, 1'b0, 32'h0000_2040, 2'd2, 1'b1);
    drain();
    check(flits_seen - f0 == 1 && beats_seen == b0, "R5",
          128'({32'(flits_seen - f0), 32'(beats_seen - b0)}), 128'({32'd1, 32'd0}));

    // linear 4 x 32-byte write: one header
    f0 = flits_seen;
    for (int p = 0; p < 4; p++)
      issue(4'h7, 4'h1, 1'b1, 32'h0000_3000 + 32 * p, 2'd3, p == 3);
    drain();
    check(flits_seen - f0 == 17, "R6", 128'(flits_seen - f0), 128'(17));

    // broken chain: 8B at 0x4000, 0x4008, then jump to 0x4100
    f0 = flits_seen;
    issue(4'h2, 4'h2, 1'b1, 32'h0000_4000, 2'd1, 1'b0);
    issue(4'h2, 4'h2, 1'b1, 32'h0000_4008, 2'd1, 1'b0);
    issue(4'h2, 4'h2, 1'b1, 32'h0000_4100, 2'd1, 1'b1);
    drain();
    check(flits_seen - f0 == 5, "R7 jump", 128'(flits_seen - f0), 128'(5));

    // size change at linear address still needs a header
    f0 = flits_seen;
    issue(4'h4, 4'h0, 1'b1, 32'h0000_5000, 2'd1, 1'b0);
    issue(4'h4, 4'h0, 1'b1, 32'h0000_5008, 2'd2, 1'b1);
    drain();
    check(flits_seen - f0 == 5, "R7 size", 128'(flits_seen - f0), 128'(5));

    // 4-byte packets in both halves of the word
    issue(4'h5, 4'h3, 1'b1, 32'h0000_6000, 2'd0, 1'b0);
    issue(4'h5, 4'h3, 1'b1, 32'h0000_6004, 2'd0, 1'b1);
    drain();

    // stall the link to hold flits
    ready_pct = 20;
    issue(4'h6, 4'h6, 1'b1, 32'h0000_7000, 2'd2, 1'b0);
    issue(4'h6, 4'h6, 1'b0, 32'h0000_7010, 2'd2, 1'b1);
    drain();
    ready_pct = 70;

    // random traffic
    for (int t = 0; t < 250; t++) begin
      int np;
      logic [3:0] d, q;
      logic [1:0] sz;
      logic [31:0] a;
      logic wr;
      np = 1 + ($urandom % 5);
      d = 4'($urandom); q = 4'($urandom); sz = 2'($urandom);
      a = $urandom & ~((32'd4 << sz) - 1);
      if (t % 50 == 25) ready_pct = 30 + ($urandom % 70);
      for (int p = 0; p < np; p++) begin
        wr = (($urandom % 4) != 0);
        if (p > 0) begin
          if (($urandom % 10) < 7) a = a + (32'd4 << sz);
          else begin
            sz = 2'($urandom);
            a = $urandom & ~((32'd4 << sz) - 1);
          end
        end
        issue(d, q, wr, a, sz, p == np - 1);
      end
    end
    drain();
    check(exp_q.size() == 0, "R8 all flits seen", 128'(exp_q.size()), 128'(0));

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end
endmodule